// File: doc/BRIEF.md
# Emulator Mode Entry Controller

This block decides when a small processor core switches into a debug emulator mode and when it returns to normal execution. The core's sequencer feeds it an instruction-boundary pulse, breakpoint and trace flags, the regular interrupt request, an RTE-completed pulse and a strobe from the debug command path that asks for an emulator interrupt. The block answers with a one-cycle exception-start request, the vector offset and frame size of the exception to run, which PC to save, and level outputs for emulator mode, the alternate address space, the interrupt mask and a processor-status code.

There are four ways into emulator mode. A command seen during a fixed count of clocks after reset release turns the reset exception itself into an emulator entry. An enabled breakpoint instruction, an enabled trace event, or a pending emulator interrupt taken at an instruction boundary does the same. Every emulator entry selects the alternate address space, and that space stays selected until the closing RTE completes. Regular interrupts and normal trace exceptions are also arbitrated here, because the emulator interrupt has to take its place among them in priority.

Top module: `emu_entry_ctrl`

## Requirements
- R1: After reset release, `exc_start` pulses exactly once, on the output sample following the 16th rising clock edge with reset high, with `exc_vec_off` = 0x004 and `emu_mode` low when no command arrived. While reset is low, `exc_start`, `emu_mode`, `alt_space`, `int_mask` and `pst` are all 0.
- R2: A `dbg_emu_cmd` pulse sampled at any of those 16 edges makes the reset exception an emulator entry: `emu_mode` = 1, `alt_space` = 1, `pst` = 0x8, and the offset is still 0x004.
- R3: A command sampled after the window has closed leaves reset handling normal. It becomes a pending emulator interrupt, which is taken at the next instruction boundary with offset 0x030, a four-word frame (`exc_frame_six` = 0) and `exc_save_cur_pc` = 0 (next PC).
- R4: At a boundary with `bkpt_insn` and `bkpt_en` both high, an emulator entry starts with offset 0x030, a four-word frame and `exc_save_cur_pc` = 1 (PC of the breakpoint). When `bkpt_en` is low, `bkpt_insn` starts nothing.
- R5: At a boundary with `trace_pend` high, a trace exception starts with offset 0x024 and a six-word frame (`exc_frame_six` = 1). It enters emulator mode only when `trace_en` is high. Otherwise it is a normal exception with `alt_space` = 0.
- R6: When several sources are present at one boundary, the order is: enabled breakpoint first, then trace, then emulator interrupt, then regular interrupt.
- R7: No exception other than the reset exception starts except on the sample after an `insn_boundary` pulse. A pending emulator interrupt waits for a boundary.
- R8: While `emu_mode` is high, `int_mask` is high and `irq_req` starts no exception.
- R9: `pst` is 0x8 from an emulator entry until the first instruction boundary after it, and 0x0 at all other times.
- R10: `rte_done` while running in emulator mode clears `emu_mode` and `alt_space` on the next sample. `rte_done` outside emulator mode has no effect.
- R11: In emulator mode no entry source starts an exception. A command received in emulator mode stays pending and is taken at the first boundary after exit.
- R12: A regular interrupt taken in normal mode uses offset `IRQ_VEC_OFF` (default 0x064), a four-word frame, the next PC and `alt_space` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset line of the core |
| dbg_emu_cmd | input | 1 | Debug command strobe: request emulator interrupt |
| bkpt_en | input | 1 | Allow breakpoint instructions to enter emulator mode |
| trace_en | input | 1 | Allow trace exceptions to enter emulator mode |
| insn_boundary | input | 1 | Pulse at the completion of an instruction |
| bkpt_insn | input | 1 | The completing instruction is a breakpoint |
| trace_pend | input | 1 | A trace exception is due at this boundary |
| irq_req | input | 1 | Regular interrupt request |
| rte_done | input | 1 | Pulse when an RTE completes |
| emu_mode | output | 1 | Emulator mode active |
| exc_start | output | 1 | One-cycle exception start request |
| exc_vec_off | output | 10 | Vector offset of the started exception |
| exc_frame_six | output | 1 | 1 = six-word frame, 0 = four-word frame |
| exc_save_cur_pc | output | 1 | 1 = save current PC, 0 = save next PC |
| alt_space | output | 1 | Steer fetches and stack accesses to the alternate space |
| int_mask | output | 1 | Regular interrupts masked |
| pst | output | 4 | Processor status code, 0x8 during emulator exception processing |

## Verification
The hardest case to reach is the border of the post-reset window. A command on the 16th edge must still turn the reset exception into an emulator entry, while one on the 17th must become a pending emulator interrupt with no visible effect until a boundary arrives. The bench releases reset on a falling edge, counts rising edges itself, and places the command pulse on a chosen edge index. A second hard case is a command that arrives while emulator mode is active. The bench sends it together with breakpoint, trace and interrupt stimulus during emulator mode, then completes the RTE, and checks that nothing started in between and that the held request fires at the first boundary afterwards.

// File: rtl/emu_pkg.sv
package emu_pkg;

  localparam int VEC_W = 10;
  localparam int PST_W = 4;

  typedef enum logic [1:0] {
    ST_RWAIT,
    ST_NORM,
    ST_EMU_EXC,
    ST_EMU_RUN
  } mode_st_e;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_BKPT,
    SRC_TRACE,
    SRC_EMUINT,
    SRC_IRQ
  } src_e;

  localparam logic [VEC_W-1:0] OFF_RESET  = 10'h004;
  localparam logic [VEC_W-1:0] OFF_TRACE  = 10'h024;
  localparam logic [VEC_W-1:0] OFF_EMUINT = 10'h030;

  localparam logic [PST_W-1:0] PST_IDLE    = 4'h0;
  localparam logic [PST_W-1:0] PST_EMU_EXC = 4'h8;

  // vector offset for a boundary source
  function automatic logic [VEC_W-1:0] vec_of(src_e s, logic [VEC_W-1:0] irq_off);
    case (s)
      SRC_BKPT, SRC_EMUINT: return OFF_EMUINT;
      SRC_TRACE:            return OFF_TRACE;
      SRC_IRQ:              return irq_off;
      default:              return OFF_RESET;
    endcase
  endfunction

  function automatic logic six_word(src_e s);
    return s == SRC_TRACE;
  endfunction

  function automatic logic saves_cur_pc(src_e s);
    return s == SRC_BKPT;
  endfunction

  // does this source steer into emulator mode
  function automatic logic enters_emu(src_e s, logic trc_en);
    case (s)
      SRC_BKPT, SRC_EMUINT: return 1'b1;
      SRC_TRACE:            return trc_en;
      default:              return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/emu_rst_window.sv
module emu_rst_window #(
  parameter int WIN = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic active,
  output logic last
);
  localparam int CW = $clog2(WIN + 1);

  logic [CW-1:0] cnt;

  assign last = active && (cnt == CW'(WIN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      active <= 1'b1;
    end else if (active) begin
      if (last) active <= 1'b0;
      else      cnt    <= cnt + 1'b1;
    end
  end

  // window closes right after its final cycle and stays closed (R1)
  assert_window_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> !active);
  assert_window_stays_shut_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> !active);

endmodule

// File: rtl/emu_src_arb.sv
module emu_src_arb
  import emu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic take_ok,
  input  logic bkpt_hit,
  input  logic trace_hit,
  input  logic emu_req,
  input  logic irq_hit,
  output src_e src
);

  always_comb begin
    src = SRC_NONE;
    if (take_ok) begin
      if (bkpt_hit)       src = SRC_BKPT;
      else if (trace_hit) src = SRC_TRACE;
      else if (emu_req)   src = SRC_EMUINT;
      else if (irq_hit)   src = SRC_IRQ;
    end
  end

  // regular interrupt only wins when nothing above it asks (R6)
  assert_irq_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_IRQ) |-> !(bkpt_hit || trace_hit || emu_req));
  // emulator interrupt never overrides trace or breakpoint (R6)
  assert_emuint_below_trace_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (src == SRC_EMUINT) |-> !(bkpt_hit || trace_hit));

endmodule

// File: rtl/emu_entry_ctrl.sv
module emu_entry_ctrl
  import emu_pkg::*;
#(
  parameter int               RST_WINDOW  = 16,
  parameter logic [VEC_W-1:0] IRQ_VEC_OFF = 10'h064
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_emu_cmd,
  input  logic             bkpt_en,
  input  logic             trace_en,
  input  logic             insn_boundary,
  input  logic             bkpt_insn,
  input  logic             trace_pend,
  input  logic             irq_req,
  input  logic             rte_done,
  output logic             emu_mode,
  output logic             exc_start,
  output logic [VEC_W-1:0] exc_vec_off,
  output logic             exc_frame_six,
  output logic             exc_save_cur_pc,
  output logic             alt_space,
  output logic             int_mask,
  output logic [PST_W-1:0] pst
);

  // named internal events
  logic     win_active;
  logic     win_last;
  logic     rst_take;
  logic     rst_emu;
  logic     emu_req;
  logic     take_ok;
  logic     sel_emu;
  logic     rte_exit;
  src_e     src;
  mode_st_e state_q, state_d;
  logic     rst_cmd_q;
  logic     pend_q;

  emu_rst_window #(.WIN(RST_WINDOW)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (win_active),
    .last   (win_last)
  );

  always_comb begin
    take_ok  = (state_q == ST_NORM) && insn_boundary;
    emu_req  = pend_q || (dbg_emu_cmd && !win_active);
    rst_take = win_active && win_last;
    rst_emu  = rst_cmd_q || dbg_emu_cmd;
    rte_exit = (state_q == ST_EMU_RUN) && rte_done;
  end

  emu_src_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_ok   (take_ok),
    .bkpt_hit  (bkpt_insn && bkpt_en),
    .trace_hit (trace_pend),
    .emu_req   (emu_req),
    .irq_hit   (irq_req),
    .src       (src)
  );

  assign sel_emu = enters_emu(src, trace_en);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RWAIT:   if (rst_take) state_d = rst_emu ? ST_EMU_EXC : ST_NORM;
      ST_NORM:    if (sel_emu) state_d = ST_EMU_EXC;
      ST_EMU_EXC: if (insn_boundary) state_d = ST_EMU_RUN;
      ST_EMU_RUN: if (rte_exit) state_d = ST_NORM;
      default:    state_d = ST_RWAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q         <= ST_RWAIT;
      rst_cmd_q       <= 1'b0;
      pend_q          <= 1'b0;
      exc_start       <= 1'b0;
      exc_vec_off     <= '0;
      exc_frame_six   <= 1'b0;
      exc_save_cur_pc <= 1'b0;
    end else begin
      state_q <= state_d;
      if (win_active && dbg_emu_cmd) rst_cmd_q <= 1'b1;
      if (src == SRC_EMUINT) pend_q <= 1'b0;
      else if (emu_req)      pend_q <= 1'b1;
      if (rst_take) begin
        exc_start       <= 1'b1;
        exc_vec_off     <= OFF_RESET;
        exc_frame_six   <= 1'b0;
        exc_save_cur_pc <= 1'b0;
      end else if (src != SRC_NONE) begin
        exc_start       <= 1'b1;
        exc_vec_off     <= vec_of(src, IRQ_VEC_OFF);
        exc_frame_six   <= six_word(src);
        exc_save_cur_pc <= saves_cur_pc(src);
      end else begin
        exc_start <= 1'b0;
      end
    end
  end

  always_comb begin
    emu_mode  = (state_q == ST_EMU_EXC) || (state_q == ST_EMU_RUN);
    alt_space = emu_mode;
    int_mask  = emu_mode;
    pst       = (state_q == ST_EMU_EXC) ? PST_EMU_EXC : PST_IDLE;
  end

  // reset exception starts as the window closes, with the reset offset (R1)
  assert_reset_vector_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(win_active) |-> (exc_start && exc_vec_off == OFF_RESET));
  // a command latched during the window yields an emulator reset (R2)
  assert_reset_emu_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_take && rst_emu) |=> (emu_mode && alt_space));
  // non-reset starts only follow a boundary (R7)
  assert_start_on_boundary_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_start && !$past(win_active)) |-> $past(insn_boundary));
  // nothing starts while in emulator mode (R8, R11)
  assert_no_start_in_emu_R8: assert property (@(posedge clk) disable iff (!rst_n)
    emu_mode |=> !exc_start);
  // status code marks emulator entry (R9)
  assert_pst_on_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_start && emu_mode) |-> (pst == PST_EMU_EXC));
  // RTE leaves emulator mode and the alternate space (R10)
  assert_rte_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rte_exit |=> (!emu_mode && !alt_space));
  // trace exceptions always use the long frame (R5)
  assert_trace_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_start && exc_vec_off == OFF_TRACE) |-> exc_frame_six);
  // a held request survives emulator mode (R11)
  assert_pend_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && emu_mode) |=> pend_q);

endmodule

// File: tb/tb_emu_entry_ctrl.sv
module tb_emu_entry_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_emu_cmd = 1'b0, bkpt_en = 1'b0, trace_en = 1'b0, insn_boundary = 1'b0;
  logic bkpt_insn = 1'b0, trace_pend = 1'b0, irq_req = 1'b0, rte_done = 1'b0;
  logic emu_mode, exc_start, exc_frame_six, exc_save_cur_pc, alt_space, int_mask;
  logic [9:0] exc_vec_off;
  logic [3:0] pst;

  int n_chk = 0;
  int n_err = 0;

  always #5 clk = ~clk;

  emu_entry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .dbg_emu_cmd(dbg_emu_cmd), .bkpt_en(bkpt_en),
    .trace_en(trace_en), .insn_boundary(insn_boundary), .bkpt_insn(bkpt_insn),
    .trace_pend(trace_pend), .irq_req(irq_req), .rte_done(rte_done),
    .emu_mode(emu_mode), .exc_start(exc_start), .exc_vec_off(exc_vec_off),
    .exc_frame_six(exc_frame_six), .exc_save_cur_pc(exc_save_cur_pc),
    .alt_space(alt_space), .int_mask(int_mask), .pst(pst)
  );

  typedef struct packed {
    logic       bk, bken, tr, tren, cmd, irq;
    logic       start;
    logic [9:0] vec;
    logic       six, cur, emu;
  } row_t;

  localparam int NROW = 10;
  localparam row_t TBL [NROW] = '{
    '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 1'b1,10'h030,1'b0,1'b1,1'b1}, // R4 enabled
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 1'b0,10'h000,1'b0,1'b0,1'b0}, // R4 disabled
    '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b0, 1'b1,10'h024,1'b1,1'b0,1'b1}, // R5 enabled
    '{1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 1'b1,10'h024,1'b1,1'b0,1'b0}, // R5 normal
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b0, 1'b1,10'h030,1'b0,1'b0,1'b1}, // R3 cmd at boundary
    '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,10'h064,1'b0,1'b0,1'b0}, // R12 irq
    '{1'b0,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1,10'h024,1'b1,1'b0,1'b1}, // R6 trace wins
    '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1, 1'b1,10'h030,1'b0,1'b0,1'b1}, // R6 emu int over irq
    '{1'b1,1'b1,1'b1,1'b1,1'b0,1'b0, 1'b1,10'h030,1'b0,1'b1,1'b1}, // R6 bkpt wins
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b1, 1'b1,10'h064,1'b0,1'b0,1'b0}  // R6 disabled bkpt, irq
  };
  localparam string TAG [NROW] = '{"R4","R4","R5","R5","R3","R12","R6","R6","R6","R6"};

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic clear_in();
    dbg_emu_cmd = 0; bkpt_en = 0; trace_en = 0; insn_boundary = 0;
    bkpt_insn = 0; trace_pend = 0; irq_req = 0; rte_done = 0;
  endtask

  // one cycle of stimulus: drive at negedge, sample at the next negedge
  task automatic step(input logic bnd, input logic cmd, input logic rte,
                      input logic irq);
    insn_boundary = bnd; dbg_emu_cmd = cmd; rte_done = rte; irq_req = irq;
    @(posedge clk); @(negedge clk);
    clear_in();
  endtask

  // reset, then count 16 edges; cmd_edge selects an edge for the command (0 = none)
  task automatic run_window(input int cmd_edge);
    logic early;
    logic exp_emu;
    early = 1'b0;
    exp_emu = (cmd_edge >= 1) && (cmd_edge <= 16);
    clear_in();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 1; i <= 16; i++) begin
      dbg_emu_cmd = (i == cmd_edge);
      @(posedge clk); @(negedge clk);
      dbg_emu_cmd = 1'b0;
      if (i < 16 && exc_start) early = 1'b1;
    end
    check("R1", "no early reset start", early, 0);
    check("R1", "reset start", exc_start, 1);
    check("R1", "reset offset", exc_vec_off, 10'h004);
    check(exp_emu ? "R2" : "R1", "reset emu_mode", emu_mode, exp_emu);
    check(exp_emu ? "R2" : "R1", "reset alt_space", alt_space, exp_emu);
    check("R9", "reset pst", pst, exp_emu ? 4'h8 : 4'h0);
  endtask

  initial begin : watchdog
    #(200000 * 10);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : main
    logic quiet;
    clear_in();
    // reset state (R1)
    repeat (2) @(negedge clk);
    check("R1", "reset exc_start", exc_start, 0);
    check("R1", "reset emu_mode", emu_mode, 0);
    check("R1", "reset pst", pst, 0);
    check("R1", "reset int_mask", int_mask, 0);
    check("R1", "reset alt_space", alt_space, 0);

    // table walk: one boundary from normal mode
    for (int r = 0; r < NROW; r++) begin
      run_window(0);
      @(negedge clk);
      check("R1", "start is one pulse", exc_start, 0);
      bkpt_insn = TBL[r].bk; bkpt_en = TBL[r].bken; trace_pend = TBL[r].tr;
      trace_en = TBL[r].tren; dbg_emu_cmd = TBL[r].cmd; irq_req = TBL[r].irq;
      insn_boundary = 1'b1;
      @(posedge clk); @(negedge clk);
      clear_in();
      check(TAG[r], $sformatf("row %0d start", r), exc_start, TBL[r].start);
      if (TBL[r].start) begin
        check(TAG[r], $sformatf("row %0d offset", r), exc_vec_off, TBL[r].vec);
        check(TAG[r], $sformatf("row %0d six", r), exc_frame_six, TBL[r].six);
        check(TAG[r], $sformatf("row %0d cur pc", r), exc_save_cur_pc, TBL[r].cur);
        check(TAG[r], $sformatf("row %0d emu", r), emu_mode, TBL[r].emu);
        check(TAG[r], $sformatf("row %0d alt", r), alt_space, TBL[r].emu);
        check("R9", $sformatf("row %0d pst", r), pst, TBL[r].emu ? 4'h8 : 4'h0);
      end
    end

    // window border: command on first and last edge (R2)
    run_window(1);
    run_window(16);

    // command one edge after the window (R3), no boundary yet (R7)
    run_window(0);
    step(1'b0, 1'b1, 1'b0, 1'b0);
    check("R3", "late cmd leaves mode normal", emu_mode, 0);
    quiet = 1'b1;
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b0, 1'b0, 1'b0);
      if (exc_start) quiet = 1'b0;
    end
    check("R7", "pending waits for boundary", quiet, 1);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    check("R3", "pending taken", exc_start, 1);
    check("R3", "pending offset", exc_vec_off, 10'h030);
    check("R3", "pending four-word", exc_frame_six, 0);
    check("R3", "pending next pc", exc_save_cur_pc, 0);
    check("R9", "entry pst", pst, 4'h8);

    // interrupt during emulator mode, first boundary ends exception phase
    step(1'b1, 1'b0, 1'b0, 1'b1);
    check("R8", "irq ignored in emu", exc_start, 0);
    check("R8", "int_mask in emu", int_mask, 1);
    check("R9", "pst after first boundary", pst, 4'h0);
    check("R9", "still emu", emu_mode, 1);

    // every source during emulator mode; command must be held (R11)
    bkpt_en = 1'b1; bkpt_insn = 1'b1; trace_en = 1'b1; trace_pend = 1'b1;
    step(1'b1, 1'b1, 1'b0, 1'b1);
    check("R11", "no entry while in emu", exc_start, 0);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    check("R10", "rte exits", emu_mode, 0);
    check("R10", "rte drops alt space", alt_space, 0);
    check("R11", "no start on exit", exc_start, 0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    check("R11", "held cmd taken after exit", exc_start, 1);
    check("R11", "held cmd offset", exc_vec_off, 10'h030);
    check("R11", "held cmd enters emu", emu_mode, 1);

    // RTE outside emulator mode (R10)
    run_window(0);
    step(1'b0, 1'b0, 1'b1, 1'b0);
    check("R10", "stray rte emu", emu_mode, 0);
    check("R10", "stray rte start", exc_start, 0);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    check("R10", "stray rte leaves nothing pending", exc_start, 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule